// File: doc/BRIEF.md
# End-of-Write Status Read Responder

This block forms the byte a host sees when it reads a byte-wide nonvolatile memory, and it lets the host tell when a write cycle has finished. While the write controller reports that programming is in progress, a read does not return array contents. It returns a status pattern instead:

- the top bit is the inverse of the top bit of the last byte written;
- the bit below it flips once per read access;
- the six low bits repeat the last written byte.

The pattern stops on the first cycle in which the busy flag is low. From that cycle on, the byte returned is the array data again.

The block receives the active-low chip-enable, output-enable and write-enable strobes already sampled into its clock domain. It also receives the busy flag and the last written byte from the write controller, and the array read data. It drives an 8-bit value and an enable for the tri-state data bus. A read path of RD_LAT register stages stands in for access-time modelling, so every result appears RD_LAT clock edges after the inputs it was formed from.

A host reads any location repeatedly. It can stop polling when the top bit matches the data it wrote, or when two successive reads return the same bit 6.

Top module: `eow_status_responder`

## Requirements
- R1: While reset is asserted and after reset, until a read is sampled, oe_o is 0 and data_o is 0.
- R2: A read is sampled in a cycle with ce_ni=0, oe_ni=0 and we_ni=1. oe_o is 1 exactly when a read was sampled RD_LAT edges earlier. Whenever oe_o is 0, data_o is 0, including when we_ni is 0 with both enables low.
- R3: For a read sampled with busy_i=0, data_o equals arr_data_i from that sample.
- R4: For a read sampled with busy_i=1, data_o[7] equals the inverse of last_data_i[7] from that sample.
- R5: For a read sampled with busy_i=1, data_o[5:0] equals last_data_i[5:0] from that sample.
- R6: An access starts in a cycle where a read is sampled and none was sampled in the previous cycle. With busy_i=1, data_o[6] flips at each access start and stays constant for the rest of that access.
- R7: busy_i rising from 0 to 1 restarts the status bit. The first access that starts in a write cycle returns data_o[6]=1, the second returns 0, and so on.
- R8: On the first sample after busy_i falls, even within an access that is already running, data_o returns to array data on all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Sampled chip enable, active low |
| oe_ni | input | 1 | Sampled output enable, active low |
| we_ni | input | 1 | Sampled write enable, active low |
| busy_i | input | 1 | Programming in progress, from the write controller |
| last_data_i | input | 8 | Last byte written, from the write controller |
| arr_data_i | input | 8 | Array read data |
| data_o | output | 8 | Read value, 0 when not driven |
| oe_o | output | 1 | Data bus drive enable |

## Verification
The checker assumes that busy_i, last_data_i and the strobes are already synchronous to clk_i. It also assumes that the write controller keeps last_data_i meaningful while busy_i is high. The block itself checks neither of these.

The stimulus drives every input a fixed offset after the clock edge. It changes last_data_i only at the start of each write episode, while arr_data_i and the strobes are randomised every cycle. Directed sequences cover these cases:
- the first and second accesses after a write starts;
- busy falling in the middle of a held read;
- both enables low with the write strobe active.

// File: rtl/eow_pkg.sv
package eow_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned POLL_BIT = BYTE_W - 1;
  localparam int unsigned TGL_BIT = BYTE_W - 2;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  en;
    byte_t val;
  } rd_beat_t;
endpackage

// File: rtl/eow_strobe_dec.sv
module eow_strobe_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic busy_i,
  output logic rd_req_o,
  output logic acc_start_o,
  output logic busy_rise_o
);
  logic rd_q, busy_q;

  assign rd_req_o    = ~ce_ni & ~oe_ni & we_ni;
  assign acc_start_o = rd_req_o & ~rd_q;
  assign busy_rise_o = busy_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      rd_q   <= rd_req_o;
      busy_q <= busy_i;
    end
  end
endmodule

// File: rtl/eow_toggle.sv
module eow_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic busy_rise_i,
  input  logic acc_start_i,
  output logic tgl_eff_o,
  output logic tgl_q_o
);
  logic base;

  // restart at write-cycle start, flip on access start while busy
  assign base      = busy_rise_i ? 1'b0 : tgl_q_o;
  assign tgl_eff_o = base ^ (acc_start_i & busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q_o <= 1'b0;
    else         tgl_q_o <= tgl_eff_o;
  end
endmodule

// File: rtl/eow_out_pipe.sv
module eow_out_pipe
  import eow_pkg::*;
#(
  parameter int unsigned LAT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rd_beat_t in_i,
  output rd_beat_t head_o,
  output rd_beat_t out_o
);
  rd_beat_t [LAT-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= '0;
    end else begin
      stg[0] <= in_i;
      for (int i = 1; i < int'(LAT); i++) stg[i] <= stg[i-1];
    end
  end

  assign head_o = stg[0];
  assign out_o  = stg[LAT-1];
endmodule

// File: rtl/eow_status_responder.sv
module eow_status_responder
  import eow_pkg::*;
#(
  parameter int unsigned RD_LAT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        we_ni,
  input  logic        busy_i,
  input  logic [7:0]  last_data_i,
  input  logic [7:0]  arr_data_i,
  output logic [7:0]  data_o,
  output logic        oe_o
);
  logic     rd_req, acc_start, busy_rise;
  logic     tgl_eff, tgl_q;
  byte_t    status_val;
  rd_beat_t beat_in, head, tail;

  eow_strobe_dec u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .oe_ni       (oe_ni),
    .we_ni       (we_ni),
    .busy_i      (busy_i),
    .rd_req_o    (rd_req),
    .acc_start_o (acc_start),
    .busy_rise_o (busy_rise)
  );

  eow_toggle u_tgl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .busy_rise_i (busy_rise),
    .acc_start_i (acc_start),
    .tgl_eff_o   (tgl_eff),
    .tgl_q_o     (tgl_q)
  );

  always_comb begin
    status_val           = last_data_i;
    status_val[POLL_BIT] = ~last_data_i[POLL_BIT];
    status_val[TGL_BIT]  = tgl_eff;
    beat_in.en           = rd_req;
    beat_in.val          = busy_i ? status_val : arr_data_i;
  end

  eow_out_pipe #(.LAT(RD_LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (beat_in),
    .head_o (head),
    .out_o  (tail)
  );

  assign oe_o   = tail.en;
  assign data_o = tail.en ? tail.val : '0;
endmodule

// File: rtl/eow_status_responder_chk.sv
module eow_status_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic [7:0] last_data_i,
  input logic [7:0] arr_data_i,
  input logic [7:0] data_o,
  input logic       oe_o,
  input logic [7:0] head_val_i,
  input logic       tgl_q_i,
  input logic       acc_start_i,
  input logic       busy_rise_i
);
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_quiet: assert (!oe_o && data_o == 8'd0);

  a_r2_undriven_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> data_o == 8'd0);

  a_r3_idle_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> head_val_i == $past(arr_data_i));

  a_r4_poll_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> head_val_i[7] == !$past(last_data_i[7]));

  a_r5_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> head_val_i[5:0] == $past(last_data_i[5:0]));

  a_r6_toggle_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tgl_q_i) |-> $past(acc_start_i || busy_rise_i));

  a_r6_bit_matches_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> head_val_i[6] == tgl_q_i);

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_rise_i && !acc_start_i) |=> !tgl_q_i);
endmodule

bind eow_status_responder eow_status_responder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .last_data_i (last_data_i),
  .arr_data_i  (arr_data_i),
  .data_o      (data_o),
  .oe_o        (oe_o),
  .head_val_i  (head.val),
  .tgl_q_i     (tgl_q),
  .acc_start_i (acc_start),
  .busy_rise_i (busy_rise)
);

// File: tb/eow_status_responder_tb.sv
module eow_status_responder_tb;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, busy_i = 1'b0;
  logic [7:0] last_data_i = 8'h00, arr_data_i = 8'h00;
  logic [7:0] data_o;
  logic oe_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model state
  logic m_tgl = 1'b0, m_busy_q = 1'b0, m_rd_q = 1'b0;
  logic [LAT-1:0] p_en = '0, p_busy = '0, p_drop = '0;
  logic [7:0] p_val [LAT];

  always #4 clk = ~clk;

  eow_status_responder #(.RD_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .busy_i(busy_i), .last_data_i(last_data_i), .arr_data_i(arr_data_i),
    .data_o(data_o), .oe_o(oe_o)
  );

  function automatic logic [7:0] status_byte(input logic [7:0] last, input logic t);
    return {~last[7], t, last[5:0]};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual oe/data=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: form expectation, advance, compare
  task automatic tick();
    logic rd, start, base, eff;
    logic [7:0] v;
    string req;
    rd    = !ce_ni && !oe_ni && we_ni;
    start = rd && !m_rd_q;
    base  = (busy_i && !m_busy_q) ? 1'b0 : m_tgl;
    eff   = base ^ (start && busy_i);
    v     = busy_i ? status_byte(last_data_i, eff) : arr_data_i;
    @(posedge clk);
    for (int i = LAT-1; i > 0; i--) begin
      p_en[i] = p_en[i-1]; p_val[i] = p_val[i-1];
      p_busy[i] = p_busy[i-1]; p_drop[i] = p_drop[i-1];
    end
    p_en[0] = rd; p_val[0] = v; p_busy[0] = busy_i; p_drop[0] = !busy_i && m_busy_q;
    m_tgl = eff; m_busy_q = busy_i; m_rd_q = rd;
    #2;
    if (oe_o !== p_en[LAT-1] || !p_en[LAT-1]) req = "R2";
    else if (p_drop[LAT-1]) req = "R8";
    else if (!p_busy[LAT-1]) req = "R3";
    else if (data_o[7] !== p_val[LAT-1][7]) req = "R4";
    else if (data_o[6] !== p_val[LAT-1][6]) req = "R6";
    else req = "R5";
    check(req, {oe_o, data_o}, {p_en[LAT-1], p_en[LAT-1] ? p_val[LAT-1] : 8'h00});
  endtask

  task automatic strobes(input logic c, input logic o, input logic w);
    ce_ni = c; oe_ni = o; we_ni = w;
  endtask

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'd2024);
    for (int i = 0; i < LAT; i++) p_val[i] = 8'h00;
    #3;
    // R1: quiet during reset
    check("R1", {oe_o, data_o}, 9'h000);
    #20;
    rst_ni = 1'b1;
    #1;
    repeat (3) tick();
    check("R1", {oe_o, data_o}, 9'h000);

    // R2: write strobe active with both enables low is not a read
    strobes(0, 0, 0); arr_data_i = 8'h5A;
    repeat (LAT + 2) tick();
    check("R2", {oe_o, data_o}, 9'h000);

    // R3: idle read returns array data
    strobes(0, 0, 1); arr_data_i = 8'hC3;
    repeat (LAT + 1) tick();
    check("R3", {oe_o, data_o}, {1'b1, 8'hC3});
    strobes(1, 1, 1); tick();

    // R7: first access of a write cycle shows 1 on bit 6, second shows 0
    busy_i = 1'b1; last_data_i = 8'hA5;
    repeat (2) tick();
    strobes(0, 0, 1);
    repeat (LAT + 1) tick();
    check("R7", {oe_o, data_o}, {1'b1, 8'h65});
    strobes(0, 1, 1); tick();
    strobes(0, 0, 1);
    repeat (LAT + 2) tick();
    check("R6", {oe_o, data_o}, {1'b1, 8'h25});
    // R8: busy falls during the held read
    busy_i = 1'b0; arr_data_i = 8'h3C;
    repeat (LAT) tick();
    check("R8", {oe_o, data_o}, {1'b1, 8'h3C});
    strobes(1, 1, 1); tick();
    // R7: new write cycle restarts the bit, access via chip enable
    busy_i = 1'b1; last_data_i = 8'h12;
    tick();
    strobes(0, 0, 1);
    repeat (LAT + 1) tick();
    check("R7", {oe_o, data_o}, {1'b1, 8'hD2});
    strobes(1, 0, 1); tick();
    busy_i = 1'b0; tick();

    // random episodes
    for (int e = 0; e < 150; e++) begin
      int len;
      busy_i = $urandom_range(0, 2) != 0;
      last_data_i = 8'($urandom);
      len = $urandom_range(4, 40);
      for (int c = 0; c < len; c++) begin
        int pick;
        pick = $urandom_range(0, 9);
        if (pick < 6) strobes(0, 0, 1);
        else strobes(1'($urandom), 1'($urandom), 1'($urandom));
        arr_data_i = 8'($urandom);
        tick();
      end
    end
    strobes(1, 1, 1); busy_i = 1'b0;
    repeat (LAT + 2) tick();
    check("R2", {oe_o, data_o}, 9'h000);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule